// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits beside a receive MAC and watches the bytes of an incoming frame, beginning with the first byte after the start-frame delimiter. It decides whether the destination address is one the station wants. It holds four programmable station-address slots and compares each armed slot with the 48-bit destination. It also flags broadcast and group (multicast) destinations, and it compares the length/type field with a programmable type value.

Software loads each slot as a low word and a high word through a single-cycle write port. The order of those writes arms and disarms the slot, so a slot never takes part in a compare while only half of it is loaded. The address flags become valid once the sixth destination byte has been taken and stay until the next frame starts. The type flag follows once the fourteenth byte has been taken.

Top module: `rx_addr_filter`

## Requirements
- R1: Slot k reports a hit when it is armed and the six destination bytes equal {high[15:0], low[31:0]}, with received byte 0 in low[7:0] and byte 5 in high[15:8]; address 21:43:65:87:A9:CB matches low 0x87654321 and high 0x0000CBA9.
- R2: After reset all outputs are 0 and every slot is disarmed; a disarmed slot never reports a hit.
- R3: Writing a slot's high word arms it and writing its low word disarms it; a write made between bytes of a frame applies to that frame's compare at byte 5.
- R4: Write select 2k loads the low word of slot k, select 2k+1 loads its high word, and select 8 loads the type value from data bits 15:0; selects 9 to 15 change nothing.
- R5: bcast_o is set for an all-ones destination only while no_bcast_i is 0 when byte 5 is taken.
- R6: mcast_o equals bit 0 of destination byte 0, so it is also set for broadcast.
- R7: accept_o is set when any slot hits or broadcast is flagged.
- R8: The address flags change in the cycle after byte 5 is taken, are 0 after byte 4, hold through the rest of the frame, and a sof_i pulse clears every flag on the next edge.
- R9: A frame of fewer than six bytes leaves all flags at 0.
- R10: type_hit_o is set in the cycle after byte 13 when {byte 12, byte 13} equals the type value (byte 12 in bits 15:8), and holds until the next sof_i.
- R11: While the type value is 0, type_hit_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse, given in a cycle of its own before byte 0 |
| byte_vld_i | input | 1 | byte_i carries a frame byte this cycle |
| byte_i | input | 8 | Received frame byte |
| no_bcast_i | input | 1 | 1 blocks broadcast recognition |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Register select |
| wr_data_i | input | 32 | Register write data |
| slot_hit_o | output | 4 | Per-slot address match |
| accept_o | output | 1 | Any slot hit or broadcast |
| bcast_o | output | 1 | Broadcast destination |
| mcast_o | output | 1 | Group destination |
| type_hit_o | output | 1 | Type field matches the type value |

## Verification
The bench sweeps all sixteen arm patterns of the four slots and, for each, sends frames aimed at every slot, at broadcast and at unrelated unicast and group addresses. A design with swapped byte packing, or one that ignores the arm state, shows hits on the wrong slots. Frames cut short at every length below six catch flags that are taken from stale bytes of an earlier frame. Low-word and high-word writes placed in the middle of a frame catch an arm state that is only sampled at frame start. Writes to the unused selects, a zero type value, and broadcast with blocking on catch loose decoding, a type compare without its enable, and a broadcast that ignores its blocking bit.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned DA_BYTES    = 6;
  localparam int unsigned ADDR_W      = BYTE_W * DA_BYTES;
  localparam int unsigned LOW_W       = 32;
  localparam int unsigned HIGH_W      = ADDR_W - LOW_W;
  localparam int unsigned TYPE_W      = 16;
  localparam int unsigned TYPE_HI_POS = 12;
  localparam int unsigned TYPE_LO_POS = 13;
  localparam int unsigned POS_MAX     = 14;
  localparam int unsigned POS_W       = $clog2(POS_MAX + 1);
endpackage

// File: rtl/rx_addr_byte_track.sv
module rx_addr_byte_track
  import rx_addr_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ADDR_W-1:0] da_o,
  output logic              da_done_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              type_done_o
);
  localparam int unsigned HELD_W = ADDR_W - BYTE_W;

  logic [POS_W-1:0]  pos_q;
  logic [HELD_W-1:0] da_q;
  logic [BYTE_W-1:0] type_hi_q;
  logic              take;

  assign take = byte_vld_i && !sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      da_q      <= '0;
      type_hi_q <= '0;
    end else if (sof_i) begin
      pos_q <= '0;
    end else if (byte_vld_i) begin
      if (pos_q < POS_W'(POS_MAX)) pos_q <= pos_q + 1'b1;
      for (int i = 0; i < int'(DA_BYTES) - 1; i++) begin
        if (pos_q == POS_W'(i)) da_q[i*BYTE_W +: BYTE_W] <= byte_i;
      end
      if (pos_q == POS_W'(TYPE_HI_POS)) type_hi_q <= byte_i;
    end
  end

  // last destination byte joins the held bytes combinationally
  assign da_o        = {byte_i, da_q};
  assign da_done_o   = take && (pos_q == POS_W'(DA_BYTES - 1));
  assign type_o      = {type_hi_q, byte_i};
  assign type_done_o = take && (pos_q == POS_W'(TYPE_LO_POS));
endmodule

// File: rtl/rx_addr_wr_dec.sv
module rx_addr_wr_dec #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                 wr_en_i,
  input  logic [SEL_W-1:0]     wr_sel_i,
  output logic [NUM_SLOTS-1:0] low_we_o,
  output logic [NUM_SLOTS-1:0] high_we_o,
  output logic                 type_we_o
);
  localparam int unsigned TYPE_SEL = 2 * NUM_SLOTS;

  for (genvar k = 0; k < int'(NUM_SLOTS); k++) begin : g_slot
    assign low_we_o[k]  = wr_en_i && (wr_sel_i == SEL_W'(2 * k));
    assign high_we_o[k] = wr_en_i && (wr_sel_i == SEL_W'(2 * k + 1));
  end

  assign type_we_o = wr_en_i && (wr_sel_i == SEL_W'(TYPE_SEL));
endmodule

// File: rtl/rx_addr_slot.sv
module rx_addr_slot
  import rx_addr_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              low_we_i,
  input  logic              high_we_i,
  input  logic [LOW_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] da_i,
  output logic              en_o,
  output logic              hit_o
);
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      high_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (low_we_i) begin
        low_q <= wr_data_i;
        en_q  <= 1'b0;
      end
      if (high_we_i) begin
        high_q <= wr_data_i[HIGH_W-1:0];
        en_q   <= 1'b1;
      end
    end
  end

  assign en_o  = en_q;
  assign hit_o = en_q && (da_i == {high_q, low_q});
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  input  logic                 no_bcast_i,
  input  logic                 wr_en_i,
  input  logic [SEL_W-1:0]     wr_sel_i,
  input  logic [31:0]          wr_data_i,
  output logic [NUM_SLOTS-1:0] slot_hit_o,
  output logic                 accept_o,
  output logic                 bcast_o,
  output logic                 mcast_o,
  output logic                 type_hit_o
);
  logic [ADDR_W-1:0]    da_w;
  logic                 da_done;
  logic [TYPE_W-1:0]    type_w;
  logic                 type_done;
  logic [NUM_SLOTS-1:0] low_we, high_we, slot_en, slot_hit_w;
  logic                 type_we;
  logic [TYPE_W-1:0]    type_id_q;
  logic                 bcast_w;
  logic [NUM_SLOTS-1:0] hit_q;
  logic                 acc_q, bcast_q, mcast_q, type_q;

  rx_addr_byte_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .da_o        (da_w),
    .da_done_o   (da_done),
    .type_o      (type_w),
    .type_done_o (type_done)
  );

  rx_addr_wr_dec #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .low_we_o  (low_we),
    .high_we_o (high_we),
    .type_we_o (type_we)
  );

  for (genvar k = 0; k < int'(NUM_SLOTS); k++) begin : g_slot
    rx_addr_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .low_we_i  (low_we[k]),
      .high_we_i (high_we[k]),
      .wr_data_i (wr_data_i),
      .da_i      (da_w),
      .en_o      (slot_en[k]),
      .hit_o     (slot_hit_w[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      type_id_q <= '0;
    else if (type_we) type_id_q <= wr_data_i[TYPE_W-1:0];
  end

  assign bcast_w = (&da_w) && !no_bcast_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= '0;
      acc_q   <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
      type_q  <= 1'b0;
    end else if (sof_i) begin
      hit_q   <= '0;
      acc_q   <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
      type_q  <= 1'b0;
    end else begin
      if (da_done) begin
        hit_q   <= slot_hit_w;
        acc_q   <= (|slot_hit_w) || bcast_w;
        bcast_q <= bcast_w;
        mcast_q <= da_w[0];
      end
      // zero type value disables the compare
      if (type_done) type_q <= (type_id_q != '0) && (type_w == type_id_q);
    end
  end

  assign slot_hit_o = hit_q;
  assign accept_o   = acc_q;
  assign bcast_o    = bcast_q;
  assign mcast_o    = mcast_q;
  assign type_hit_o = type_q;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SEL_W     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sof_i,
  input logic                 no_bcast_i,
  input logic                 wr_en_i,
  input logic [SEL_W-1:0]     wr_sel_i,
  input logic                 da_done_i,
  input logic [NUM_SLOTS-1:0] slot_en_i,
  input logic [15:0]          type_id_i,
  input logic [NUM_SLOTS-1:0] slot_hit_o,
  input logic                 accept_o,
  input logic                 bcast_o,
  input logic                 mcast_o,
  input logic                 type_hit_o
);
  a_r2_hit_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(da_done_i) |-> ((slot_hit_o & ~$past(slot_en_i)) == '0));

  for (genvar k = 0; k < int'(NUM_SLOTS); k++) begin : g_arm
    a_r3_low_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == SEL_W'(2 * k)) |=> !slot_en_i[k]);
    a_r3_high_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == SEL_W'(2 * k + 1)) |=> slot_en_i[k]);
  end

  a_r4_free_sel_keeps_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i > SEL_W'(2 * NUM_SLOTS)) |=> $stable(slot_en_i) && $stable(type_id_i));

  a_r5_bcast_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcast_o) |-> $past(!no_bcast_i));

  a_r6_bcast_is_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> mcast_o);

  a_r7_accept_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o == ((|slot_hit_o) || bcast_o));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sof_i && !da_done_i) |-> ($stable(slot_hit_o) && $stable(bcast_o) && $stable(mcast_o)));

  a_r8_sof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (!accept_o && !mcast_o && !type_hit_o && slot_hit_o == '0));

  a_r11_zero_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(type_hit_o) |-> $past(type_id_i != '0));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sof_i      (sof_i),
  .no_bcast_i (no_bcast_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .da_done_i  (da_done),
  .slot_en_i  (slot_en),
  .type_id_i  (type_id_q),
  .slot_hit_o (slot_hit_o),
  .accept_o   (accept_o),
  .bcast_o    (bcast_o),
  .mcast_o    (mcast_o),
  .type_hit_o (type_hit_o)
);

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0, no_bc = 1'b0, wr_en = 1'b0;
  logic [7:0]  bdat = '0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  slot_hit;
  logic        accept, bcast, mcast, type_hit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_low [4];
  logic [15:0] m_high [4];
  logic        m_en [4];
  logic [15:0] m_type;

  always #4 clk = ~clk;

  rx_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(bdat),
    .no_bcast_i(no_bc), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .slot_hit_o(slot_hit), .accept_o(accept), .bcast_o(bcast), .mcast_o(mcast),
    .type_hit_o(type_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_low(input int k, input logic [31:0] d);
    wr(4'(2 * k), d); m_low[k] = d; m_en[k] = 1'b0;
  endtask

  task automatic set_high(input int k, input logic [31:0] d);
    wr(4'(2 * k + 1), d); m_high[k] = d[15:0]; m_en[k] = 1'b1;
  endtask

  task automatic set_type(input logic [15:0] d);
    wr(4'd8, {16'hA5A5, d}); m_type = d;
  endtask

  function automatic logic [7:0] fbyte(input logic [47:0] da, input logic [15:0] ty, input int i);
    if (i < 6)       return da[8*i +: 8];
    else if (i < 12) return 8'(8'h30 + i);
    else if (i == 12) return ty[15:8];
    else             return ty[7:0];
  endfunction

  function automatic logic [3:0] exp_hits(input logic [47:0] da);
    logic [3:0] h;
    for (int k = 0; k < 4; k++) h[k] = m_en[k] && ({m_high[k], m_low[k]} == da);
    return h;
  endfunction

  task automatic chk_addr(input logic [47:0] da, input bit full, input string req);
    logic [3:0] h;
    logic b;
    h = full ? exp_hits(da) : 4'h0;
    b = full && (da == 48'hFFFF_FFFF_FFFF) && !no_bc;
    chk({req, " R1 slot hits"}, 32'(slot_hit), 32'(h));
    chk({req, " R5 bcast"}, 32'(bcast), 32'(b));
    chk({req, " R6 mcast"}, 32'(mcast), 32'(full && da[0]));
    chk({req, " R7 accept"}, 32'(accept), 32'((|h) || b));
  endtask

  task automatic start_frame();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    chk("R8 sof clears", {27'd0, slot_hit, accept}, 32'd0);
    chk("R8 sof clears type", 32'(type_hit), 32'd0);
  endtask

  task automatic send_bytes(input logic [47:0] da, input logic [15:0] ty, input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      bdat = fbyte(da, ty, i); vld = 1'b1;
      @(negedge clk);
      vld = 1'b0;
      if (i == 4) chk("R8 zero after byte 4", {27'd0, slot_hit, accept}, 32'd0);
      if (i == 5) chk_addr(da, 1'b1, "R8 at byte 5");
    end
  endtask

  task automatic end_checks(input logic [47:0] da, input logic [15:0] ty, input int n, input string req);
    chk_addr(da, n >= 6, req);
    chk({req, " R10 type"}, 32'(type_hit), 32'(n >= 14 && m_type != 16'h0 && ty == m_type));
  endtask

  task automatic frame(input logic [47:0] da, input logic [15:0] ty, input int n, input string req);
    start_frame();
    send_bytes(da, ty, 0, n);
    repeat (2) @(negedge clk);
    end_checks(da, ty, n, req);
  endtask

  function automatic logic [47:0] slot_addr(input int k);
    return {16'(16'h0A00 + 16'h0111 * k), 32'(32'h1234_5600 + 2 * k)};
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) begin m_low[k] = '0; m_high[k] = '0; m_en[k] = 1'b0; end
    m_type = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset outputs", {26'd0, slot_hit, accept, bcast}, 32'd0);
    chk("R2 reset outputs", {30'd0, mcast, type_hit}, 32'd0);
    rst_n = 1'b1;

    frame(48'h0, 16'h0, 14, "R2 disarmed zero address");
    frame(slot_addr(0), 16'h0, 14, "R2 disarmed slot address");

    // worked packing example
    set_low(1, 32'h8765_4321);
    set_high(1, 32'h0000_CBA9);
    set_type(16'h4321);
    frame(48'hCBA9_8765_4321, 16'h4321, 14, "R1 example");
    frame(48'hCBA9_8765_4321, 16'h2143, 14, "R10 swapped type");
    frame(48'h2143_6587_A9CB, 16'h4322, 14, "R1 reversed order");

    // sweep arm patterns
    for (int mask = 0; mask < 16; mask++) begin
      for (int k = 0; k < 4; k++) begin
        set_low(k, slot_addr(k)[31:0]);
        if (mask[k]) set_high(k, {16'h0, slot_addr(k)[47:32]});
      end
      for (int k = 0; k < 4; k++) frame(slot_addr(k), 16'h4321, 14, "R3 R4 sweep");
      frame(slot_addr(mask % 4) | 48'h1, 16'h1111, 14, "R6 sweep group");
      frame(48'hFFFF_FFFF_FFFF, 16'h4321, 14, "R5 sweep bcast");
      frame(48'h0000_0000_0002 + 48'(mask), 16'h4321, 14, "R7 sweep other");
    end

    no_bc = 1'b1;
    frame(48'hFFFF_FFFF_FFFF, 16'h4321, 14, "R5 blocked bcast");
    no_bc = 1'b0;

    set_high(2, {16'h0, slot_addr(2)[47:32]});
    for (int n = 0; n < 6; n++) frame(48'hFFFF_FFFF_FFFF, 16'h0, n, "R9 short bcast");
    for (int n = 0; n < 6; n++) frame(slot_addr(2), 16'h0, n, "R9 short slot");

    // mid-frame low write disarms
    start_frame();
    send_bytes(slot_addr(2), 16'h4321, 0, 3);
    set_low(2, slot_addr(2)[31:0]);
    send_bytes(slot_addr(2), 16'h4321, 3, 14);
    end_checks(slot_addr(2), 16'h4321, 14, "R3 mid-frame disarm");
    chk("R3 mid-frame disarm hit", 32'(slot_hit[2]), 32'd0);

    // mid-frame high write arms
    start_frame();
    send_bytes(slot_addr(2), 16'h4321, 0, 3);
    set_high(2, {16'h0, slot_addr(2)[47:32]});
    send_bytes(slot_addr(2), 16'h4321, 3, 14);
    end_checks(slot_addr(2), 16'h4321, 14, "R3 mid-frame arm");
    chk("R3 mid-frame arm hit", 32'(slot_hit[2]), 32'd1);

    set_type(16'h0);
    frame(slot_addr(2), 16'h0000, 14, "R11 zero type");
    chk("R11 zero type hit", 32'(type_hit), 32'd0);

    // unused selects must change nothing
    set_type(16'h88B5);
    set_low(0, slot_addr(0)[31:0]);
    set_high(0, {16'h0, slot_addr(0)[47:32]});
    for (int s = 9; s < 16; s++) wr(4'(s), 32'h0);
    frame(slot_addr(0), 16'h88B5, 14, "R4 free selects");
    chk("R4 free selects slot0", 32'(slot_hit[0]), 32'd1);
    chk("R4 free selects type", 32'(type_hit), 32'd1);

    repeat (5) @(negedge clk);
    chk("R10 type held", 32'(type_hit), 32'd1);
    chk("R8 addr held", 32'(slot_hit), 32'(exp_hits(slot_addr(0))));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule